// File: doc/BRIEF.md
# GPIO Interrupt Detection Unit

This block turns 32 general-purpose input lines into four interrupt requests for a chip-level interrupt controller. Every line is brought into the clock domain by a two-flop synchronizer. A per-pin polarity bit then either passes the synchronized value through or inverts it, and the result is the visible data-in value. Two paths derive causes from that value. The level path uses data-in as it is. The edge path latches a rising transition of data-in into a sticky cause register. Separate mask registers gate each path. The masked causes of each byte of pins are ORed onto one group output.

The edge path only detects 0-to-1 transitions of the post-polarity value. Setting the polarity bit therefore turns it into a falling-edge detector. A pin-direction vector comes in from outside, and only pins marked as inputs raise causes. Software uses a small register port to program the registers and read them back. Edge causes are cleared by writing zeros.

Top module: `gpio_irq_detect`

## Requirements
- R1: The data-in register (address 4, read-only) reads the synchronized pin value XOR the polarity register (address 0). A pin change is visible two clock edges after it is applied, and a polarity write takes effect on the edge that performs the write.
- R2: A pin contributes a level cause while its data-in bit is 1 and its bit in the level mask (address 1) is 1. The cause drops when data-in returns to 0.
- R3: A 0-to-1 transition of a data-in bit sets the matching bit of the edge-cause register (address 3). That bit stays set after data-in falls again.
- R4: The pending value of a pin is (data-in AND level mask) OR (edge cause AND edge mask, address 2). A set edge cause with its edge-mask bit at 0 raises no interrupt.
- R5: groupIrq[g] is the OR of the pending values of pins 8g to 8g+7, for g = 0..3.
- R6: A write to the edge-cause address clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R7: A pin whose pinIsInput bit is 0 sets no edge cause and adds nothing to any group output.
- R8: After reset, the polarity, level-mask, edge-mask and edge-cause registers read 0, and all group outputs are 0.
- R9: With the polarity bit set, a falling pin sets the edge cause, and a rising pin does not.
- R10: If a new edge and a clearing write of the same edge-cause bit fall on the same clock edge, the bit ends up set.
- R11: A polarity write that changes a data-in bit from 0 to 1 sets that pin's edge cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pinIn | input | 32 | Raw pin levels, asynchronous |
| pinIsInput | input | 32 | Direction vector, 1 = pin is an input |
| regAddr | input | 3 | Register address: 0 polarity, 1 level mask, 2 edge mask, 3 edge cause, 4 data-in |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational; unused addresses read 0 |
| groupIrq | output | 4 | One interrupt per byte of pins |

## Verification
The edge-cause register has two writers that can act on the same clock edge: the edge detector and a software clearing write to the same bit. The bench applies a pin rise and counts the synchronizer and edge-detector stages, so that a write of all zeros to the cause register lands on exactly the edge where the detector sets the bit. It then reads the register back and expects the bit to be set. A separate case confirms that a clearing write with no edge present removes only the bits written as zero.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_POL       = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_LVL_MASK  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_EDGE_MASK = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CAUSE     = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_DATA_IN   = 3'd4;

  typedef enum logic [2:0] {
    RD_POL, RD_LVL, RD_EDGE, RD_CAUSE, RD_DIN, RD_NONE
  } rdSel_e;

  typedef struct packed {
    logic   wrPol;
    logic   wrLvlMask;
    logic   wrEdgeMask;
    logic   wrCause;
    rdSel_e rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctrlStrobe_t       strobe
);
  always_comb begin
    strobe = '0;
    strobe.rdSel = RD_NONE;
    unique case (regAddr)
      ADDR_POL: begin
        strobe.wrPol = regWrEn;
        strobe.rdSel = RD_POL;
      end
      ADDR_LVL_MASK: begin
        strobe.wrLvlMask = regWrEn;
        strobe.rdSel = RD_LVL;
      end
      ADDR_EDGE_MASK: begin
        strobe.wrEdgeMask = regWrEn;
        strobe.rdSel = RD_EDGE;
      end
      ADDR_CAUSE: begin
        strobe.wrCause = regWrEn;
        strobe.rdSel = RD_CAUSE;
      end
      ADDR_DATA_IN: strobe.rdSel = RD_DIN;
      default: strobe.rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS   = 32,
  parameter int GROUP_SIZE = 8,
  localparam int NUM_GROUPS = NUM_PINS / GROUP_SIZE
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pinIn,
  input  logic [NUM_PINS-1:0]   pinIsInput,
  input  logic [NUM_PINS-1:0]   regWrData,
  input  ctrlStrobe_t           strobe,
  output logic [NUM_PINS-1:0]   regRdData,
  output logic [NUM_PINS-1:0]   polarity,
  output logic [NUM_PINS-1:0]   levelMask,
  output logic [NUM_PINS-1:0]   edgeMask,
  output logic [NUM_PINS-1:0]   edgeCause,
  output logic [NUM_PINS-1:0]   dataIn,
  output logic [NUM_GROUPS-1:0] groupIrq
);
  logic [NUM_PINS-1:0] syncStage1, syncStage2, dataInPrev;
  logic [NUM_PINS-1:0] riseDet, causeKept, pending;

  // Two-flop synchronizer followed by the polarity XOR.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncStage1 <= '0;
      syncStage2 <= '0;
    end else begin
      syncStage1 <= pinIn;
      syncStage2 <= syncStage1;
    end
  end

  assign dataIn = syncStage2 ^ polarity;

  // Configuration registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      polarity  <= '0;
      levelMask <= '0;
      edgeMask  <= '0;
    end else begin
      if (strobe.wrPol)      polarity  <= regWrData;
      if (strobe.wrLvlMask)  levelMask <= regWrData;
      if (strobe.wrEdgeMask) edgeMask  <= regWrData;
    end
  end

  // Edge detection on the post-polarity value; a new edge beats a clear.
  assign riseDet   = dataIn & ~dataInPrev & pinIsInput;
  assign causeKept = strobe.wrCause ? (edgeCause & regWrData) : edgeCause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataInPrev <= '0;
      edgeCause  <= '0;
    end else begin
      dataInPrev <= dataIn;
      edgeCause  <= causeKept | riseDet;
    end
  end

  assign pending = ((dataIn & levelMask) | (edgeCause & edgeMask)) & pinIsInput;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gen_group
    assign groupIrq[g] = |pending[g*GROUP_SIZE +: GROUP_SIZE];
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_POL:   regRdData = polarity;
      RD_LVL:   regRdData = levelMask;
      RD_EDGE:  regRdData = edgeMask;
      RD_CAUSE: regRdData = edgeCause;
      RD_DIN:   regRdData = dataIn;
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS   = 32,
  parameter int GROUP_SIZE = 8,
  localparam int NUM_GROUPS = NUM_PINS / GROUP_SIZE
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pinIn,
  input  logic [NUM_PINS-1:0]   pinIsInput,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWrEn,
  input  logic [NUM_PINS-1:0]   regWrData,
  output logic [NUM_PINS-1:0]   regRdData,
  output logic [NUM_GROUPS-1:0] groupIrq
);
  ctrlStrobe_t         strobe;
  logic [NUM_PINS-1:0] polarity, levelMask, edgeMask, edgeCause, dataIn;

  gpio_irq_ctrl ctrl_i (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobe  (strobe)
  );

  gpio_irq_datapath #(
    .NUM_PINS   (NUM_PINS),
    .GROUP_SIZE (GROUP_SIZE)
  ) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pinIn      (pinIn),
    .pinIsInput (pinIsInput),
    .regWrData  (regWrData),
    .strobe     (strobe),
    .regRdData  (regRdData),
    .polarity   (polarity),
    .levelMask  (levelMask),
    .edgeMask   (edgeMask),
    .edgeCause  (edgeCause),
    .dataIn     (dataIn),
    .groupIrq   (groupIrq)
  );
endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker #(
  parameter int NUM_PINS   = 32,
  parameter int NUM_GROUPS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_PINS-1:0]   pinIsInput,
  input logic [NUM_PINS-1:0]   regWrData,
  input logic                  wrCause,
  input logic [NUM_PINS-1:0]   edgeCause,
  input logic [NUM_PINS-1:0]   levelMask,
  input logic [NUM_PINS-1:0]   edgeMask,
  input logic [NUM_GROUPS-1:0] groupIrq
);
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wrCause |=> ((edgeCause & $past(edgeCause)) == $past(edgeCause))); // R3

  AST_CLEAR_ONLY_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    wrCause |=> ((($past(edgeCause) & ~edgeCause) & $past(regWrData)) == '0)); // R6

  AST_NO_CAUSE_ON_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edgeCause & ~$past(edgeCause) & ~$past(pinIsInput)) == '0)); // R7

  AST_MASKED_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (levelMask == '0 && edgeMask == '0) |-> (groupIrq == '0)); // R4

  AST_NONINPUT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pinIsInput == '0) |-> (groupIrq == '0)); // R7
endmodule

bind gpio_irq_detect gpio_irq_checker #(
  .NUM_PINS   (NUM_PINS),
  .NUM_GROUPS (NUM_GROUPS)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .pinIsInput (pinIsInput),
  .regWrData  (regWrData),
  .wrCause    (strobe.wrCause),
  .edgeCause  (edgeCause),
  .levelMask  (levelMask),
  .edgeMask   (edgeMask),
  .groupIrq   (groupIrq)
);

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pinIn = '0;
  logic [31:0] pinIsInput = '1;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [3:0]  groupIrq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_detect dut_i (
    .clk(clk), .rst_n(rst_n), .pinIn(pinIn), .pinIsInput(pinIsInput),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .groupIrq(groupIrq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic cleanUp();
    pinIn = '0; pinIsInput = '1;
    wrReg(3'd0, '0); wrReg(3'd1, '0); wrReg(3'd2, '0);
    waitCyc(3);
    wrReg(3'd3, '0);
  endtask

  task automatic testReset();
    logic [31:0] v;
    check("R8 groupIrq", {28'd0, groupIrq}, 32'd0);
    for (int a = 0; a < 4; a++) begin
      rdReg(a[2:0], v);
      check("R8 register", v, 32'd0);
    end
  endtask

  task automatic testPolarity();
    logic [31:0] v;
    pinIn[3] = 1'b1;
    waitCyc(2);
    rdReg(3'd4, v); check("R1 data-in follows pin", v, 32'h8);
    wrReg(3'd0, 32'h8);
    rdReg(3'd4, v); check("R1 data-in inverted", v, 32'h0);
    cleanUp();
  endtask

  task automatic testLevel();
    wrReg(3'd1, 32'h20);
    pinIn[5] = 1'b1;
    waitCyc(2);
    check("R2 level raises group0", {28'd0, groupIrq}, 32'h1);
    pinIn[5] = 1'b0;
    waitCyc(2);
    check("R2 level drops", {28'd0, groupIrq}, 32'h0);
    wrReg(3'd0, 32'h20);
    check("R2 inverted level raises", {28'd0, groupIrq}, 32'h1);
    cleanUp();
  endtask

  task automatic testEdge();
    logic [31:0] v;
    wrReg(3'd2, 32'h400);
    pinIn[10] = 1'b1;
    waitCyc(3);
    check("R3 edge raises group1", {28'd0, groupIrq}, 32'h2);
    pinIn[10] = 1'b0;
    waitCyc(3);
    check("R3 edge cause sticky", {28'd0, groupIrq}, 32'h2);
    rdReg(3'd3, v); check("R3 cause bit", v, 32'h400);
    wrReg(3'd2, 32'h0);
    check("R4 masked edge silent", {28'd0, groupIrq}, 32'h0);
    cleanUp();
  endtask

  task automatic testClear();
    logic [31:0] v;
    pinIn[10] = 1'b1; pinIn[11] = 1'b1;
    waitCyc(3);
    pinIn = '0;
    waitCyc(3);
    wrReg(3'd3, ~32'h400);
    rdReg(3'd3, v); check("R6 clear one bit", v, 32'h800);
    wrReg(3'd3, 32'h0);
    rdReg(3'd3, v); check("R6 clear all", v, 32'h0);
    cleanUp();
  endtask

  task automatic testFalling();
    logic [31:0] v;
    pinIn[20] = 1'b1;
    waitCyc(3);
    wrReg(3'd3, '0);
    wrReg(3'd0, 32'h0010_0000);
    waitCyc(2);
    rdReg(3'd3, v); check("R9 no cause on rise with polarity", v, 32'h0);
    pinIn[20] = 1'b0;
    waitCyc(3);
    rdReg(3'd3, v); check("R9 falling edge latched", v, 32'h0010_0000);
    cleanUp();
  endtask

  task automatic testPolToggle();
    logic [31:0] v;
    wrReg(3'd0, 32'h80);
    waitCyc(1);
    rdReg(3'd3, v); check("R11 polarity flip sets cause", v, 32'h80);
    cleanUp();
  endtask

  task automatic testGroups();
    wrReg(3'd1, '1);
    pinIn[16] = 1'b1;
    waitCyc(2);
    check("R5 pin16 to group2", {28'd0, groupIrq}, 32'h4);
    pinIn[31] = 1'b1;
    waitCyc(2);
    check("R5 pin31 to group3", {28'd0, groupIrq}, 32'hC);
    pinIn[16] = 1'b0;
    waitCyc(2);
    check("R5 group2 drops alone", {28'd0, groupIrq}, 32'h8);
    cleanUp();
  endtask

  task automatic testDirection();
    logic [31:0] v;
    pinIsInput = ~32'h1;
    wrReg(3'd1, 32'h1); wrReg(3'd2, 32'h1);
    pinIn[0] = 1'b1;
    waitCyc(3);
    check("R7 output pin raises nothing", {28'd0, groupIrq}, 32'h0);
    rdReg(3'd3, v); check("R7 output pin no cause", v, 32'h0);
    cleanUp();
  endtask

  task automatic testRace();
    logic [31:0] v;
    pinIn[12] = 1'b1;
    waitCyc(2);
    regAddr = 3'd3; regWrData = '0; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    rdReg(3'd3, v); check("R10 edge wins over clear", v, 32'h1000);
    cleanUp();
  endtask

  initial begin
    waitCyc(2);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testPolarity();
    testLevel();
    testEdge();
    testClear();
    testFalling();
    testPolToggle();
    testGroups();
    testDirection();
    testRace();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule